// File: doc/BRIEF.md
# Flash Byte Program and Chip Erase Sequencer

This block sits on the host side of an asynchronous byte-wide flash bus. It takes one request at a time over a valid/ready handshake. Each request names an operation (byte program or whole-chip erase), a target address, a data byte and a completion-detection method. The sequencer drives the keyed unlock writes and the command writes. The write strobe pulses are timed by clock-cycle counters derived from nanosecond parameters. It then reads the flash repeatedly until the part reports that the internal operation has finished. The end of the operation is signalled with a one-cycle `done` pulse, and `err` shows whether the read limit ran out first.

Completion can be detected in one of two ways. Data polling compares the most significant data bit with its final value: the target data bit for a program, one for an erase. Toggle polling waits until bit 6 reads the same in two consecutive reads. Bus pad cells and the flash array are outside the block, so the data bus appears as separate in, out and drive-enable signals.

Top module: `flash_prog_seq`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `done` is 0, `f_ce_n`, `f_oe_n` and `f_we_n` are 1, and `f_dq_oe` is 0.
- R2: A program request (`req_op`=0) produces exactly four bus writes, in this order (address/data, hex): 5555/AA, 2AAA/55, 5555/A0, then the target address with the request data.
- R3: An erase request (`req_op`=1) produces exactly six bus writes, in this order: 5555/AA, 2AAA/55, 5555/80, 5555/AA, 2AAA/55, 5555/10.
- R4: Every `f_we_n` low pulse lasts at least ceil(T_WP_NS/CLK_NS) cycles. `f_addr` and `f_dout` are stable during the whole pulse and in the cycle before it.
- R5: Whenever `f_we_n` is low, `f_oe_n` is high, `f_ce_n` is low and `f_dq_oe` is 1.
- R6: With data polling (`req_poll`=0), the operation ends without error at the first read whose bit 7 equals the request data bit 7 (program) or equals 1 (erase).
- R7: With toggle polling (`req_poll`=1), the operation ends without error at the first read whose bit 6 equals bit 6 of the read just before it. The first read never ends the operation.
- R8: Each polling read holds `f_oe_n` low for at least ceil(T_ACC_NS/CLK_NS) cycles. `f_oe_n` stays high for at least ceil(T_OEH_NS/CLK_NS) cycles before every read. `f_dq_oe` is 0 while `f_oe_n` is low. Reads use the request address.
- R9: If PROG_POLL_MAX reads (program) or ERASE_POLL_MAX reads (erase) pass without completion, the operation ends with `err`=1 after exactly that many reads.
- R10: A completion seen on the last permitted read ends the operation with `err`=0.
- R11: `done` is a single-cycle pulse, `req_ready` is 1 in the cycle of `done`, and a request is taken only when `req_valid` and `req_ready` are both 1.
- R12: While an operation runs (`req_ready`=0), `req_valid` and the request fields have no effect on the bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 1 | 0 = byte program, 1 = chip erase |
| req_poll | input | 1 | 0 = data polling on bit 7, 1 = toggle polling on bit 6 |
| req_addr | input | ADDR_W | Target byte address, also used for polling reads |
| req_data | input | DATA_W | Byte to program |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Read limit reached without completion, valid with done |
| f_addr | output | ADDR_W | Flash address bus |
| f_dout | output | DATA_W | Data driven toward the flash |
| f_dq_oe | output | 1 | Drive enable for the data pads |
| f_din | input | DATA_W | Data read from the flash |
| f_ce_n | output | 1 | Chip enable, active low |
| f_oe_n | output | 1 | Output enable, active low |
| f_we_n | output | 1 | Write enable, active low |

## Verification
Two outcomes can fall on the same polling read: reaching the read limit and seeing completion. The bench provokes this by making its flash model finish on exactly the last permitted read, and again one read later. The first case must give `err`=0 and the second `err`=1, each after the limit's number of reads. A second coincidence is a new request held on `req_valid` while an operation is still running. This is judged by comparing the captured write sequence with the one the original request calls for.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_e;
  typedef enum logic {POLL_DATA = 1'b0, POLL_TOGGLE = 1'b1} poll_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SETUP, S_WLOW, S_WHIGH, S_PGAP, S_PLOW
  } seq_st_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] tgt_data,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_last
);

  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(16'h2AAA);

  always_comb begin
    cmd_addr = KEY_A;
    cmd_data = DATA_W'(8'hAA);
    cmd_last = 1'b0;
    case (step)
      3'd0: begin cmd_addr = KEY_A; cmd_data = DATA_W'(8'hAA); end
      3'd1: begin cmd_addr = KEY_B; cmd_data = DATA_W'(8'h55); end
      3'd2: begin
        cmd_addr = KEY_A;
        cmd_data = (op == OP_ERASE) ? DATA_W'(8'h80) : DATA_W'(8'hA0);
      end
      3'd3: begin
        if (op == OP_ERASE) begin
          cmd_addr = KEY_A; cmd_data = DATA_W'(8'hAA);
        end else begin
          cmd_addr = tgt_addr; cmd_data = tgt_data; cmd_last = 1'b1;
        end
      end
      3'd4: begin cmd_addr = KEY_B; cmd_data = DATA_W'(8'h55); end
      3'd5: begin cmd_addr = KEY_A; cmd_data = DATA_W'(8'h10); cmd_last = 1'b1; end
      default: cmd_last = 1'b1;
    endcase
  end

endmodule

// File: rtl/flash_step_timer.sv
module flash_step_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_cnt,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_cnt - W'(1);
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge
  import flash_seq_pkg::*;
(
  input  poll_e mode,
  input  logic  rd_msb,
  input  logic  rd_tog,
  input  logic  prev_tog,
  input  logic  have_prev,
  input  logic  target_msb,
  output logic  complete
);

  always_comb begin
    if (mode == POLL_DATA) complete = (rd_msb == target_msb);
    else                   complete = have_prev && (rd_tog == prev_tog);
  end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W         = 20,
  parameter int DATA_W         = 8,
  parameter int CLK_NS         = 4,
  parameter int T_WP_NS        = 90,
  parameter int T_WPH_NS       = 90,
  parameter int T_ACC_NS       = 90,
  parameter int T_OEH_NS       = 150,
  parameter int PROG_POLL_MAX  = 4000,
  parameter int ERASE_POLL_MAX = 200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic              req_poll,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DATA_W-1:0] f_dout,
  output logic              f_dq_oe,
  input  logic [DATA_W-1:0] f_din,
  output logic              f_ce_n,
  output logic              f_oe_n,
  output logic              f_we_n
);

  localparam int N_WP    = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int N_WPH   = ns_to_cyc(T_WPH_NS, CLK_NS);
  localparam int N_ACC   = ns_to_cyc(T_ACC_NS, CLK_NS);
  localparam int N_OEH   = ns_to_cyc(T_OEH_NS, CLK_NS);
  localparam int N_M1    = (N_WP > N_WPH) ? N_WP : N_WPH;
  localparam int N_M2    = (N_ACC > N_OEH) ? N_ACC : N_OEH;
  localparam int N_MAX   = (N_M1 > N_M2) ? N_M1 : N_M2;
  localparam int TMR_W   = $clog2(N_MAX + 1);
  localparam int LIM_MAX = (PROG_POLL_MAX > ERASE_POLL_MAX) ? PROG_POLL_MAX : ERASE_POLL_MAX;
  localparam int POLL_W  = $clog2(LIM_MAX + 1);
  localparam int MSB     = DATA_W - 1;
  localparam int TOG     = DATA_W - 2;

  seq_st_e           st;
  op_e               op_q;
  poll_e             mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [2:0]        step;
  logic [POLL_W-1:0] rd_cnt;
  logic              prev_tog;
  logic              have_prev;

  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic              cmd_last;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_exp;
  logic              complete;
  logic              target_msb;
  logic [POLL_W-1:0] rd_next;
  logic [POLL_W-1:0] poll_lim;
  logic              unused_din_bits;

  assign unused_din_bits = ^f_din[TOG-1:0];
  assign target_msb = (op_q == OP_ERASE) ? 1'b1 : data_q[MSB];
  assign rd_next    = rd_cnt + POLL_W'(1);
  assign poll_lim   = (op_q == OP_ERASE) ? POLL_W'(ERASE_POLL_MAX) : POLL_W'(PROG_POLL_MAX);

  flash_cmd_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .op       (op_q),
    .step     (step),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .cmd_last (cmd_last)
  );

  flash_step_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_cnt (tmr_val),
    .expired  (tmr_exp)
  );

  flash_poll_judge u_judge (
    .mode       (mode_q),
    .rd_msb     (f_din[MSB]),
    .rd_tog     (f_din[TOG]),
    .prev_tog   (prev_tog),
    .have_prev  (have_prev),
    .target_msb (target_msb),
    .complete   (complete)
  );

  // each phase loads the shared timer with its own length on entry
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st)
      S_SETUP: begin tmr_load = 1'b1;    tmr_val = TMR_W'(N_WP);  end
      S_WLOW:  begin tmr_load = tmr_exp; tmr_val = TMR_W'(N_WPH); end
      S_WHIGH: begin tmr_load = tmr_exp; tmr_val = TMR_W'(N_OEH); end
      S_PGAP:  begin tmr_load = tmr_exp; tmr_val = TMR_W'(N_ACC); end
      S_PLOW:  begin tmr_load = tmr_exp; tmr_val = TMR_W'(N_OEH); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      req_ready <= 1'b1;
      done      <= 1'b0;
      err       <= 1'b0;
      f_addr    <= '0;
      f_dout    <= '0;
      f_dq_oe   <= 1'b0;
      f_ce_n    <= 1'b1;
      f_oe_n    <= 1'b1;
      f_we_n    <= 1'b1;
      op_q      <= OP_PROG;
      mode_q    <= POLL_DATA;
      addr_q    <= '0;
      data_q    <= '0;
      step      <= '0;
      rd_cnt    <= '0;
      prev_tog  <= 1'b0;
      have_prev <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            op_q      <= op_e'(req_op);
            mode_q    <= poll_e'(req_poll);
            addr_q    <= req_addr;
            data_q    <= req_data;
            step      <= '0;
            req_ready <= 1'b0;
            err       <= 1'b0;
            st        <= S_LOAD;
          end
        end
        S_LOAD: begin
          f_addr  <= cmd_addr;
          f_dout  <= cmd_data;
          f_ce_n  <= 1'b0;
          f_dq_oe <= 1'b1;
          st      <= S_SETUP;
        end
        S_SETUP: begin
          f_we_n <= 1'b0;
          st     <= S_WLOW;
        end
        S_WLOW: begin
          if (tmr_exp) begin
            f_we_n <= 1'b1;
            st     <= S_WHIGH;
          end
        end
        S_WHIGH: begin
          if (tmr_exp) begin
            if (cmd_last) begin
              f_dq_oe   <= 1'b0;
              f_addr    <= addr_q;
              rd_cnt    <= '0;
              have_prev <= 1'b0;
              st        <= S_PGAP;
            end else begin
              step <= step + 3'd1;
              st   <= S_LOAD;
            end
          end
        end
        S_PGAP: begin
          if (tmr_exp) begin
            f_oe_n <= 1'b0;
            st     <= S_PLOW;
          end
        end
        S_PLOW: begin
          if (tmr_exp) begin
            f_oe_n    <= 1'b1;
            rd_cnt    <= rd_next;
            prev_tog  <= f_din[TOG];
            have_prev <= 1'b1;
            if (complete || (rd_next >= poll_lim)) begin
              done      <= 1'b1;
              err       <= ~complete;
              req_ready <= 1'b1;
              f_ce_n    <= 1'b1;
              st        <= S_IDLE;
            end else begin
              st <= S_PGAP;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 4,
  parameter int T_WP_NS  = 90,
  parameter int T_OEH_NS = 150
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              done,
  input logic [ADDR_W-1:0] f_addr,
  input logic [DATA_W-1:0] f_dout,
  input logic              f_dq_oe,
  input logic              f_ce_n,
  input logic              f_oe_n,
  input logic              f_we_n
);

  localparam int CW = 16;
  localparam logic [CW-1:0] NWP  = CW'(ns_to_cyc(T_WP_NS, CLK_NS));
  localparam logic [CW-1:0] NOEH = CW'(ns_to_cyc(T_OEH_NS, CLK_NS));

  logic [CW-1:0] we_low_run;
  logic [CW-1:0] oe_high_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_run  <= '0;
      oe_high_run <= '0;
    end else begin
      if (!f_we_n) we_low_run <= (we_low_run == '1) ? we_low_run : we_low_run + CW'(1);
      else         we_low_run <= '0;
      if (f_oe_n)  oe_high_run <= (oe_high_run == '1) ? oe_high_run : oe_high_run + CW'(1);
      else         oe_high_run <= '0;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (req_ready && !done && f_ce_n && f_oe_n && f_we_n && !f_dq_oe));

  // R4
  we_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(f_we_n) |-> (we_low_run >= NWP));

  // R4
  write_bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !f_we_n |-> ($stable(f_addr) && $stable(f_dout)));

  // R5
  write_strobe_mix_chk: assert property (@(posedge clk) disable iff (rst)
    !f_we_n |-> (f_oe_n && !f_ce_n && f_dq_oe));

  // R8
  read_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(f_oe_n) |-> (oe_high_run >= NOEH));

  // R8
  read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !f_oe_n |-> !f_dq_oe);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

endmodule

bind flash_prog_seq flash_prog_seq_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CLK_NS   (CLK_NS),
  .T_WP_NS  (T_WP_NS),
  .T_OEH_NS (T_OEH_NS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .done      (done),
  .f_addr    (f_addr),
  .f_dout    (f_dout),
  .f_dq_oe   (f_dq_oe),
  .f_ce_n    (f_ce_n),
  .f_oe_n    (f_oe_n),
  .f_we_n    (f_we_n)
);

// File: tb/test_flash_prog_seq.sv
module test_flash_prog_seq;

  localparam int BN_WP  = (90 + 3) / 4;
  localparam int BN_ACC = (90 + 3) / 4;
  localparam int BN_OEH = (150 + 3) / 4;
  localparam int PMAX   = 8;
  localparam int EMAX   = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic        req_poll = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        done, err;
  logic [19:0] f_addr;
  logic [7:0]  f_dout;
  logic        f_dq_oe;
  logic [7:0]  f_din;
  logic        f_ce_n, f_oe_n, f_we_n;

  always #2 clk = ~clk;

  flash_prog_seq #(
    .PROG_POLL_MAX  (PMAX),
    .ERASE_POLL_MAX (EMAX)
  ) i_flash_prog_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_poll(req_poll), .req_addr(req_addr), .req_data(req_data),
    .done(done), .err(err), .f_addr(f_addr), .f_dout(f_dout), .f_dq_oe(f_dq_oe),
    .f_din(f_din), .f_ce_n(f_ce_n), .f_oe_n(f_oe_n), .f_we_n(f_we_n)
  );

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash model state
  logic [7:0]  mem [256];
  logic [19:0] wlog_a [8];
  logic [7:0]  wlog_d [8];
  int          wlog_n = 0;
  int          exp_writes = 4;
  logic        m_erase = 1'b0;
  int          m_k = 1;
  logic        m_t7 = 1'b0;
  int          busy_left = 0;
  logic        tog = 1'b0;
  logic        we_prev = 1'b1;
  logic        oe_prev = 1'b1;
  // measurements
  bit          in_op = 1'b0;
  int          we_run, oe_hi_run, oe_lo_run, min_we, min_oeh, min_acc, rd_seen, wr_oe_bad;
  logic [19:0] rd_addr;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'hFF;

  always_comb begin
    if (busy_left > 0) f_din = {~m_t7, tog, 6'b0};
    else               f_din = mem[f_addr[7:0]];
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (f_we_n && !we_prev && !f_ce_n) begin
        if (wlog_n < 8) begin
          wlog_a[wlog_n] = f_addr;
          wlog_d[wlog_n] = f_dout;
        end
        wlog_n++;
        if (wlog_n == exp_writes) begin
          if (m_erase) for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
          else mem[f_addr[7:0]] = mem[f_addr[7:0]] & f_dout;
          busy_left = m_k - 1;
          tog = 1'b0;
        end
      end
      if (f_oe_n && !oe_prev && busy_left > 0) begin
        busy_left--;
        tog = ~tog;
      end
      if (in_op) begin
        if (!f_we_n) begin
          we_run++;
          if (!f_oe_n) wr_oe_bad++;
        end else begin
          if (we_run > 0 && we_run < min_we) min_we = we_run;
          we_run = 0;
        end
        if (!f_oe_n) begin
          if (oe_lo_run == 0) begin
            rd_seen++;
            if (oe_hi_run < min_oeh) min_oeh = oe_hi_run;
            rd_addr = f_addr;
          end
          oe_lo_run++;
          oe_hi_run = 0;
        end else begin
          if (oe_lo_run > 0 && oe_lo_run < min_acc) min_acc = oe_lo_run;
          oe_lo_run = 0;
          oe_hi_run++;
        end
      end
      we_prev = f_we_n;
      oe_prev = f_oe_n;
    end
  end

  // expected number of reads and error flag from the polling rules
  function automatic void predict(input logic mode, input int k, input logic [7:0] tb,
                                  input logic t7, input int mx,
                                  output int reads, output bit e);
    logic       prev6;
    logic [7:0] v;
    reads = mx;
    e = 1'b1;
    prev6 = 1'b0;
    for (int i = 1; i <= mx; i++) begin
      v = (i < k) ? {~t7, ((i - 1) % 2 == 1), 6'b0} : tb;
      if ((mode == 1'b0) ? (v[7] == t7) : (i > 1 && v[6] == prev6)) begin
        reads = i;
        e = 1'b0;
        return;
      end
      prev6 = v[6];
    end
  endfunction

  task automatic run_op(input logic op, input logic mode, input logic [19:0] a,
                        input logic [7:0] d, input int k, input bit poke, input string ptag);
    logic [19:0] ea [6];
    logic [7:0]  ed [6];
    int          nexp, ereads, cyc;
    bit          eerr;
    logic        t7;
    logic [7:0]  tb;
    string       wtag, ptg;
    nexp = op ? 6 : 4;
    ea[0] = 20'h05555; ed[0] = 8'hAA;
    ea[1] = 20'h02AAA; ed[1] = 8'h55;
    ea[2] = 20'h05555; ed[2] = op ? 8'h80 : 8'hA0;
    ea[3] = op ? 20'h05555 : a; ed[3] = op ? 8'hAA : d;
    ea[4] = 20'h02AAA; ed[4] = 8'h55;
    ea[5] = 20'h05555; ed[5] = 8'h10;
    t7 = op ? 1'b1 : d[7];
    tb = op ? 8'hFF : (mem[a[7:0]] & d);
    predict(mode, k, tb, t7, op ? EMAX : PMAX, ereads, eerr);
    wtag = poke ? "R12" : (op ? "R3" : "R2");
    ptg  = (ptag != "") ? ptag : (eerr ? "R9" : (mode ? "R7" : "R6"));
    exp_writes = nexp; m_erase = op; m_k = k; m_t7 = t7; wlog_n = 0;
    we_run = 0; oe_hi_run = 0; oe_lo_run = 0; rd_seen = 0; wr_oe_bad = 0;
    min_we = 1 << 20; min_oeh = 1 << 20; min_acc = 1 << 20; rd_addr = '0;
    in_op = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_poll = mode; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      for (int i = 0; i < 40; i++) begin
        req_valid = 1'b1; req_op = ~op; req_addr = ~a; req_data = ~d;
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R11", "done seen before op watchdog", done, 1);
    chk(req_ready == 1'b1, "R11", "ready during done", req_ready, 1);
    chk(err == eerr, ptg, "err flag", err, eerr);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", done, 0);
    in_op = 1'b0;
    chk(wlog_n == nexp, wtag, "write count", wlog_n, nexp);
    for (int i = 0; i < nexp && i < wlog_n; i++) begin
      chk(wlog_a[i] == ea[i], wtag, $sformatf("write %0d address", i), wlog_a[i], ea[i]);
      chk(wlog_d[i] == ed[i], wtag, $sformatf("write %0d data", i), wlog_d[i], ed[i]);
    end
    chk(min_we >= BN_WP, "R4", "shortest write pulse", min_we, BN_WP);
    chk(wr_oe_bad == 0, "R5", "OE low during write", wr_oe_bad, 0);
    chk(rd_seen == ereads, ptg, "read count", rd_seen, ereads);
    chk(min_acc >= BN_ACC, "R8", "shortest read low", min_acc, BN_ACC);
    chk(min_oeh >= BN_OEH, "R8", "shortest OE high gap", min_oeh, BN_OEH);
    chk(rd_addr == a, "R8", "read address", rd_addr, a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R1", "ready/done in reset", {req_ready, done}, 2'b10);
    chk({f_ce_n, f_oe_n, f_we_n, f_dq_oe} == 4'b1110, "R1", "strobes in reset",
        {f_ce_n, f_oe_n, f_we_n, f_dq_oe}, 4'b1110);
    rst = 1'b0;
    @(negedge clk);
    chk({f_ce_n, f_oe_n, f_we_n, f_dq_oe} == 4'b1110, "R1", "strobes after reset",
        {f_ce_n, f_oe_n, f_we_n, f_dq_oe}, 4'b1110);

    run_op(1'b1, 1'b0, 20'h12345, 8'h00, 5, 1'b0, "");     // R3 R6 erase data poll
    run_op(1'b0, 1'b0, 20'h00100, 8'h3C, 1, 1'b0, "");     // R2 R6 immediate
    run_op(1'b0, 1'b0, 20'h00207, 8'hC3, 3, 1'b1, "");     // R12 busy requests
    run_op(1'b0, 1'b1, 20'h00311, 8'h5A, 3, 1'b0, "");     // R7 odd busy length
    run_op(1'b0, 1'b1, 20'h00422, 8'h96, 4, 1'b0, "");     // R7 even busy length
    run_op(1'b0, 1'b1, 20'h00533, 8'hF0, 1, 1'b0, "");     // R7 first read never ends
    run_op(1'b0, 1'b0, 20'h00644, 8'h81, PMAX, 1'b0, "R10");
    run_op(1'b0, 1'b0, 20'h00755, 8'h81, PMAX + 1, 1'b0, "R9");
    run_op(1'b0, 1'b0, 20'h00100, 8'h80, 1, 1'b0, "R6");   // bit 7 already cleared
    run_op(1'b1, 1'b1, 20'h00000, 8'h00, EMAX + 1, 1'b0, "R9");
    run_op(1'b1, 1'b0, 20'h00000, 8'h00, EMAX, 1'b0, "R10");

    for (int n = 0; n < 16; n++) begin
      logic ro, rm;
      ro = ($urandom % 4) == 0;
      rm = $urandom % 2;
      run_op(ro, rm, 20'($urandom), 8'($urandom), 1 + int'($urandom % 12), 1'b0, "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule